// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Fractional Stop Length

This block turns bytes into asynchronous serial characters on one output line. A host pushes characters into a four-entry buffer. A shift engine then sends each character as one low start bit, five to eight data bits with the least significant bit first, an optional parity bit and a high stop period. The line rests high (mark) between characters. All timing advances only on a one-cycle enable pulse, `tick`. The pulse runs at either sixteen times or once per bit period. In the faster mode the stop period can be set in sixteenths of a bit, from one bit up to two bits.

On request the block holds the line low as a break. It marks every elapsed character time with a one-cycle pulse, so the host can count break characters and decide when to release the request. Two status outputs report the buffer state: `tx_ready` shows free space, and `underrun` flags that the engine ran out of data. Character format is sampled when each character or break character begins, so a change made mid-character takes effect at the next boundary.

Top module: `uart_tx_frac`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1, `underrun` is 0 and `brk_tick` is 0.
- R2: A character is sent as one start sample group at 0, then `5 + cfg_len` data bits, least significant bit first, then optional parity, then stop at 1. `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. The line changes only in the cycle after a `tick`.
- R3: `cfg_par` selects parity: 2'b00 none, 2'b01 even (the parity bit makes the count of ones in data plus parity even), 2'b10 odd, and 2'b11 forced, which sends `cfg_par_val`.
- R4: With `cfg_x16` = 1, every start, data and parity bit lasts 16 ticks. The stop period lasts 16 + min(`cfg_stop`, 16) ticks, so any value above 16 gives two full bits.
- R5: With `cfg_x16` = 0, every bit lasts 1 tick. The stop period is 1 tick when `cfg_stop` < 16 and 2 ticks otherwise.
- R6: The buffer holds 4 characters. `tx_ready` is 1 while fewer than 4 are stored. A write while 4 are stored is dropped and is never sent.
- R7: When a character's stop period ends and the buffer holds data, the next start bit follows on the very next tick, with no idle time between.
- R8: `underrun` is set when a stop period ends with the buffer empty and no break requested. The line then stays at 1. The flag clears on the next accepted write.
- R9: While `brk_req` is 1, a break starts at the next character boundary (idle or end of stop) and never cuts into a character. During a break `txd` is 0. `brk_tick` pulses for one cycle each time C ticks have passed, where C is the character length in ticks for the current format. When `brk_req` is 0 at such a pulse, the line returns to 1 and the break does not set `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bit-timing enable pulse (1X or 16X rate) |
| cfg_x16 | input | 1 | 1: 16 ticks per bit, 0: 1 tick per bit |
| cfg_len | input | 2 | Data bits minus five |
| cfg_par | input | 2 | Parity mode: none, even, odd, forced |
| cfg_par_val | input | 1 | Bit sent in the parity slot in forced mode |
| cfg_stop | input | 5 | Extra stop length in sixteenths of a bit |
| wr_en | input | 1 | Write strobe for the character buffer |
| wr_data | input | 8 | Character to store |
| brk_req | input | 1 | Hold the line low as a break |
| txd | output | 1 | Serial line |
| tx_ready | output | 1 | Buffer has room |
| underrun | output | 1 | Engine finished with the buffer empty |
| brk_tick | output | 1 | One-cycle pulse per elapsed break character |

## Verification
The hardest situation to reach is a break request that arrives while a character is half sent. It has to be shown that the character finishes intact and that the line falls only on the tick that ends its stop period. The stimulus raises `brk_req` twenty ticks into a frame and compares every remaining sample against the computed frame. It then expects the first low sample exactly one tick after the stop ends, and a `brk_tick` pulse a full character time later. A second hard case is the dropped fifth write. The only outside evidence for it is that the line goes idle and `underrun` rises right after the fourth frame.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4,
        ST_BRK   = 3'd5
    } utx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ODD   = 2'b10,
        PAR_FORCE = 2'b11
    } utx_par_e;

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          full,
    output logic          wr_accept
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_s;

    fifo_s q, d;
    logic  do_pop;

    always_comb begin
        d         = q;
        wr_accept = wr_en && (q.cnt != FULL_CNT);
        do_pop    = pop && (q.cnt != '0);
        if (wr_accept) begin
            d.mem[q.wp] = wr_data;
            d.wp        = (q.wp == LAST_PTR) ? '0 : q.wp + AW'(1);
        end
        if (do_pop) begin
            d.rp = (q.rp == LAST_PTR) ? '0 : q.rp + AW'(1);
        end
        d.cnt = q.cnt + CW'(wr_accept) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = q.mem[q.rp];
    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == FULL_CNT);

    // R6: a write into a full buffer leaves the stored count unchanged
    a_r6_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !pop) |=> $stable(q.cnt));

    // R7: the engine only takes a character when one is stored
    a_r7_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/utx_frame_calc.sv
module utx_frame_calc
    import utx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DW     = 8,
    parameter int STOP_W = 5,
    parameter int TW     = 8,
    parameter int NB_W   = 4
) (
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_par_val,
    input  logic              cfg_x16,
    input  logic [STOP_W-1:0] cfg_stop,
    input  logic [DW-1:0]     data,
    output logic [DW-1:0]     data_m,
    output logic [NB_W-1:0]   nbits,
    output logic              par_en,
    output logic              par_bit,
    output logic [TW-1:0]     bit_ticks,
    output logic [TW-1:0]     stop_ticks,
    output logic [TW-1:0]     char_ticks
);
    localparam int MIN_BITS = DW - 3;
    localparam logic [STOP_W-1:0] OVS_S = STOP_W'(OVS);

    logic [STOP_W-1:0] stop_ext;
    logic [TW-1:0]     slots;

    always_comb begin
        nbits = NB_W'(MIN_BITS) + NB_W'(cfg_len);
        for (int i = 0; i < DW; i++) begin
            data_m[i] = data[i] & (i < int'(nbits));
        end

        par_en  = 1'b1;
        par_bit = 1'b0;
        case (utx_par_e'(cfg_par))
            PAR_NONE:  par_en  = 1'b0;
            PAR_EVEN:  par_bit = ^data_m;
            PAR_ODD:   par_bit = ~(^data_m);
            default:   par_bit = cfg_par_val;
        endcase

        stop_ext  = (cfg_stop > OVS_S) ? OVS_S : cfg_stop;
        bit_ticks = cfg_x16 ? TW'(OVS) : TW'(1);
        if (cfg_x16) stop_ticks = TW'(OVS) + TW'(stop_ext);
        else         stop_ticks = (cfg_stop >= OVS_S) ? TW'(2) : TW'(1);

        slots      = TW'(nbits) + TW'(par_en) + TW'(1);
        char_ticks = slots * bit_ticks + stop_ticks;
    end

    // R4: in the fast mode the stop span stays between one and two bits
    always_comb begin
        a_r4_stop_span: assert (!cfg_x16 ||
            ((stop_ticks >= TW'(OVS)) && (stop_ticks <= TW'(2 * OVS))));
    end

endmodule

// File: rtl/utx_engine.sv
module utx_engine
    import utx_pkg::*;
#(
    parameter int DW   = 8,
    parameter int TW   = 8,
    parameter int NB_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            brk_req,
    input  logic            fifo_empty,
    input  logic            wr_accept,
    input  logic [DW-1:0]   data_m,
    input  logic [NB_W-1:0] nbits,
    input  logic            par_en,
    input  logic            par_bit,
    input  logic [TW-1:0]   bit_ticks,
    input  logic [TW-1:0]   stop_ticks,
    input  logic [TW-1:0]   char_ticks,
    output logic            pop,
    output logic            txd,
    output logic            underrun,
    output logic            brk_tick
);
    typedef struct packed {
        utx_state_e      st;
        logic [TW-1:0]   cnt;
        logic [NB_W-1:0] bidx;
        logic [DW-1:0]   sh;
        logic [NB_W-1:0] nbits;
        logic            par_en;
        logic            par_bit;
        logic [TW-1:0]   bit_ticks;
        logic [TW-1:0]   stop_ticks;
        logic [TW-1:0]   char_ticks;
        logic            underrun;
        logic            brk_pulse;
    } eng_s;

    eng_s q, d;
    logic boundary;
    logic bit_end;
    logic stop_end;
    logic brk_end;

    always_comb begin
        d          = q;
        d.brk_pulse = 1'b0;
        pop        = 1'b0;
        boundary   = 1'b0;
        bit_end    = (q.cnt == q.bit_ticks - TW'(1));
        stop_end   = (q.cnt == q.stop_ticks - TW'(1));
        brk_end    = (q.cnt == q.char_ticks - TW'(1));

        if (wr_accept) d.underrun = 1'b0;

        if (tick) begin
            case (q.st)
                ST_IDLE: boundary = 1'b1;
                ST_START: begin
                    if (bit_end) begin
                        d.st   = ST_DATA;
                        d.cnt  = '0;
                        d.bidx = '0;
                    end else begin
                        d.cnt = q.cnt + TW'(1);
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        d.cnt = '0;
                        d.sh  = q.sh >> 1;
                        if (q.bidx == q.nbits - NB_W'(1)) begin
                            d.st = q.par_en ? ST_PAR : ST_STOP;
                        end else begin
                            d.bidx = q.bidx + NB_W'(1);
                        end
                    end else begin
                        d.cnt = q.cnt + TW'(1);
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        d.st  = ST_STOP;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + TW'(1);
                    end
                end
                ST_STOP: begin
                    if (stop_end) boundary = 1'b1;
                    else          d.cnt = q.cnt + TW'(1);
                end
                ST_BRK: begin
                    if (brk_end) begin
                        d.brk_pulse = 1'b1;
                        d.cnt       = '0;
                        if (!brk_req) d.st = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + TW'(1);
                    end
                end
                default: d.st = ST_IDLE;
            endcase

            if (boundary) begin
                d.cnt = '0;
                if (brk_req) begin
                    d.st         = ST_BRK;
                    d.char_ticks = char_ticks;
                end else if (!fifo_empty) begin
                    pop          = 1'b1;
                    d.st         = ST_START;
                    d.sh         = data_m;
                    d.nbits      = nbits;
                    d.par_en     = par_en;
                    d.par_bit    = par_bit;
                    d.bit_ticks  = bit_ticks;
                    d.stop_ticks = stop_ticks;
                end else begin
                    d.st = ST_IDLE;
                    if ((q.st == ST_STOP) && !wr_accept) d.underrun = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.st)
            ST_START, ST_BRK: txd = 1'b0;
            ST_DATA:          txd = q.sh[0];
            ST_PAR:           txd = q.par_bit;
            default:          txd = 1'b1;
        endcase
    end

    assign underrun = q.underrun;
    assign brk_tick = q.brk_pulse;

    // R2: the line only moves on the cycle after an enable pulse
    a_r2_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd));

    // R7: characters are taken only at a character boundary on a tick
    a_r7_pop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (tick && ((q.st == ST_IDLE) || (q.st == ST_STOP))));

    // R8: with the flag up and no break, the line rests at mark
    a_r8_underrun_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && (q.st != ST_BRK)) |-> txd);

    // R9: a break-character pulse only follows a cycle spent in break
    a_r9_pulse_from_break: assert property (@(posedge clk) disable iff (!rst_n)
        brk_tick |-> ($past(q.st) == ST_BRK));

endmodule

// File: rtl/uart_tx_frac.sv
module uart_tx_frac #(
    parameter  int DW     = 8,
    parameter  int DEPTH  = 4,
    parameter  int OVS    = 16,
    localparam int STOP_W = $clog2(OVS) + 1,
    localparam int TW     = $clog2(12 * OVS + 1),
    localparam int NB_W   = $clog2(DW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_x16,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_par_val,
    input  logic [STOP_W-1:0] cfg_stop,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic              brk_req,
    output logic              txd,
    output logic              tx_ready,
    output logic              underrun,
    output logic              brk_tick
);
    logic [DW-1:0]   head;
    logic            fifo_empty;
    logic            fifo_full;
    logic            wr_accept;
    logic            pop;
    logic [DW-1:0]   data_m;
    logic [NB_W-1:0] nbits;
    logic            par_en;
    logic            par_bit;
    logic [TW-1:0]   bit_ticks;
    logic [TW-1:0]   stop_ticks;
    logic [TW-1:0]   char_ticks;

    utx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .pop       (pop),
        .rd_data   (head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .wr_accept (wr_accept)
    );

    utx_frame_calc #(.OVS(OVS), .DW(DW), .STOP_W(STOP_W), .TW(TW), .NB_W(NB_W)) u_calc (
        .cfg_len     (cfg_len),
        .cfg_par     (cfg_par),
        .cfg_par_val (cfg_par_val),
        .cfg_x16     (cfg_x16),
        .cfg_stop    (cfg_stop),
        .data        (head),
        .data_m      (data_m),
        .nbits       (nbits),
        .par_en      (par_en),
        .par_bit     (par_bit),
        .bit_ticks   (bit_ticks),
        .stop_ticks  (stop_ticks),
        .char_ticks  (char_ticks)
    );

    utx_engine #(.DW(DW), .TW(TW), .NB_W(NB_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .brk_req    (brk_req),
        .fifo_empty (fifo_empty),
        .wr_accept  (wr_accept),
        .data_m     (data_m),
        .nbits      (nbits),
        .par_en     (par_en),
        .par_bit    (par_bit),
        .bit_ticks  (bit_ticks),
        .stop_ticks (stop_ticks),
        .char_ticks (char_ticks),
        .pop        (pop),
        .txd        (txd),
        .underrun   (underrun),
        .brk_tick   (brk_tick)
    );

    assign tx_ready = !fifo_full;

endmodule

// File: tb/sim_uart_tx_frac.sv
`timescale 1ns/1ps
module sim_uart_tx_frac;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cfg_x16 = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_par_val = 1'b0;
    logic [4:0] cfg_stop = 5'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       brk_req = 1'b0;
    logic       txd, tx_ready, underrun, brk_tick;

    always #2 clk = ~clk;

    uart_tx_frac u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_x16(cfg_x16), .cfg_len(cfg_len),
        .cfg_par(cfg_par), .cfg_par_val(cfg_par_val), .cfg_stop(cfg_stop),
        .wr_en(wr_en), .wr_data(wr_data), .brk_req(brk_req),
        .txd(txd), .tx_ready(tx_ready), .underrun(underrun), .brk_tick(brk_tick)
    );

    // {data, len, par, par_val, x16, stop}
    localparam logic [18:0] VEC [0:7] = '{
        {8'hA5, 2'd3, 2'd0, 1'b0, 1'b1, 5'd0},
        {8'h3C, 2'd0, 2'd1, 1'b0, 1'b1, 5'd8},
        {8'h5B, 2'd1, 2'd2, 1'b0, 1'b1, 5'd16},
        {8'h81, 2'd2, 2'd3, 1'b1, 1'b1, 5'd31},
        {8'hC6, 2'd3, 2'd3, 1'b0, 1'b0, 5'd3},
        {8'h7E, 2'd3, 2'd1, 1'b0, 1'b0, 5'd16},
        {8'h00, 2'd3, 2'd2, 1'b0, 1'b1, 5'd1},
        {8'hFF, 2'd2, 2'd1, 1'b0, 1'b0, 5'd0}
    };

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit exp_bits [0:399];
    int exp_len = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic step();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic push(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic apply(input logic [18:0] v);
        cfg_len = v[10:9];
        cfg_par = v[8:7];
        cfg_par_val = v[6];
        cfg_x16 = v[5];
        cfg_stop = v[4:0];
    endtask

    function automatic int char_len();
        int L, S;
        L = cfg_x16 ? 16 : 1;
        S = cfg_x16 ? 16 + ((cfg_stop > 16) ? 16 : int'(cfg_stop)) : ((cfg_stop >= 16) ? 2 : 1);
        return L * (1 + 5 + int'(cfg_len) + ((cfg_par != 2'd0) ? 1 : 0)) + S;
    endfunction

    task automatic build(input logic [7:0] dat);
        int L, S, n, k, ones;
        bit pb;
        L = cfg_x16 ? 16 : 1;
        S = cfg_x16 ? 16 + ((cfg_stop > 16) ? 16 : int'(cfg_stop)) : ((cfg_stop >= 16) ? 2 : 1);
        n = 5 + int'(cfg_len);
        k = 0;
        ones = 0;
        for (int j = 0; j < L; j++) begin exp_bits[k] = 1'b0; k++; end
        for (int b = 0; b < n; b++) begin
            ones += int'(dat[b]);
            for (int j = 0; j < L; j++) begin exp_bits[k] = dat[b]; k++; end
        end
        if (cfg_par != 2'd0) begin
            if (cfg_par == 2'd1)      pb = ones[0];
            else if (cfg_par == 2'd2) pb = !ones[0];
            else                      pb = cfg_par_val;
            for (int j = 0; j < L; j++) begin exp_bits[k] = pb; k++; end
        end
        for (int j = 0; j < S; j++) begin exp_bits[k] = 1'b1; k++; end
        exp_len = k;
    endtask

    task automatic run_frame(input string req, input int brk_at);
        int bad;
        int bad_act;
        int bad_exp;
        bad = -1;
        bad_act = 0;
        bad_exp = 0;
        for (int i = 0; i < exp_len; i++) begin
            step();
            if (i == brk_at) brk_req = 1'b1;
            if ((txd !== exp_bits[i]) && (bad < 0)) begin
                bad = i;
                bad_act = int'(txd);
                bad_exp = int'(exp_bits[i]);
            end
        end
        chk(bad < 0, req, $sformatf("frame sample %0d txd", bad), bad_act, bad_exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int C;
        int bad_low;
        int bad_pulse;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(tx_ready == 1'b1, "R1", "tx_ready after reset", int'(tx_ready), 1);
        chk(underrun == 1'b0, "R1", "underrun after reset", int'(underrun), 0);
        chk(brk_tick == 1'b0, "R1", "brk_tick after reset", int'(brk_tick), 0);

        // Table walk: R2 R3 R4 R5 frame shapes, R8 underrun set and cleared
        for (int v = 0; v < 8; v++) begin
            apply(VEC[v]);
            push(VEC[v][18:11]);
            build(VEC[v][18:11]);
            chk(underrun == 1'b0, "R8", "underrun after write", int'(underrun), 0);
            run_frame(cfg_x16 ? "R2 R3 R4 vector" : "R2 R3 R5 vector", -1);
            step();
            chk(underrun == 1'b1 && txd == 1'b1, "R8", "underrun at end of frame", int'(underrun), 1);
        end

        // R6 buffer depth, dropped fifth write; R7 back-to-back frames
        apply(VEC[0]);
        push(8'h11); push(8'h22); push(8'h33);
        chk(tx_ready == 1'b1, "R6", "tx_ready with three stored", int'(tx_ready), 1);
        push(8'h44);
        chk(tx_ready == 1'b0, "R6", "tx_ready with four stored", int'(tx_ready), 0);
        push(8'h55);
        build(8'h11); run_frame("R7 first of four", -1);
        build(8'h22); run_frame("R7 second back-to-back", -1);
        build(8'h33); run_frame("R7 third back-to-back", -1);
        build(8'h44); run_frame("R7 fourth back-to-back", -1);
        step();
        chk(underrun == 1'b1 && txd == 1'b1, "R6", "idle after four frames, fifth dropped", int'(txd), 1);

        // R9 break from idle: low line, pulse every character time
        C = char_len();
        brk_req = 1'b1;
        bad_low = -1;
        bad_pulse = -1;
        for (int k = 0; k <= 2 * C; k++) begin
            step();
            if (k == C + 5) brk_req = 1'b0;
            if ((k < 2 * C) && (txd !== 1'b0) && (bad_low < 0)) bad_low = k;
            if ((brk_tick !== ((k == C) || (k == 2 * C))) && (bad_pulse < 0)) bad_pulse = k;
        end
        chk(bad_low < 0, "R9", "break line low, first high sample", bad_low, -1);
        chk(bad_pulse < 0, "R9", "break pulse position, first wrong sample", bad_pulse, -1);
        chk(txd == 1'b1, "R9", "line back at mark after release", int'(txd), 1);

        // R9 break requested mid-character waits for the boundary
        push(8'hA5);
        build(8'hA5);
        run_frame("R9 frame intact under break request", 20);
        step();
        chk(txd == 1'b0, "R9", "break starts right after stop", int'(txd), 0);
        brk_req = 1'b0;
        for (int k = 1; k <= C; k++) step();
        chk(brk_tick == 1'b1 && txd == 1'b1, "R9", "break ends after one character", int'(brk_tick), 1);
        chk(underrun == 1'b0, "R8", "break boundary leaves underrun clear", int'(underrun), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule